// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Unit

This unit gathers the single-cycle event pulses raised by the command engine, the data engine, the data FIFO and the card-detect logic of an SD host controller. It holds them as sticky flags in a status register, and it raises one interrupt line for the events that software has enabled. Software reads the flags at one address. It removes chosen flags by writing ones to a separate clear address. It enables interrupt sources through a mask register at a third address.

Two further status bits are live levels, not flags. One is the card-detect level, which reads 1 while the slot is empty. The other is the write-protect level. Both raw pins pass through a two-flop synchroniser. Any transition of the synchronised card-detect level also sets a sticky card-change flag.

Top module: `sd_event_status`

## Requirements
- R1: After reset the sticky flags (bits 0 to 10) and the mask register read zero, and `irq` is low. The card-detect synchroniser resets to "slot empty" (1) and the write-protect synchroniser resets to 0.
- R2: A 1 on `evtPulse[i]` (i from 0 to 9) for one cycle sets status bit i at the next clock edge, and the bit stays set until it is cleared. The bit order from 0 upward is: response CRC fail, data CRC fail, response timeout, data timeout, response CRC good, data CRC good, command sent, data end, FIFO underrun, FIFO overrun.
- R3: A write to the clear address (1) clears every sticky flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: When an event sets a flag in the same cycle that a clear write targets that flag, the flag ends up set.
- R5: The mask register at address 2 stores `wrData` bits 0 to 10 and reads them back. Its bits 11 and 12 always read 0.
- R6: `irq` is high exactly when some flag is set and its mask bit is also set, and it stays high until that flag is cleared or masked. An all-zero mask keeps `irq` low.
- R7: Each rising or falling transition of `cardDetRaw` sets flag bit 10 (card change) three clock edges after the input changes.
- R8: Status bit 11 shows the synchronised card-detect level and bit 12 shows the synchronised write-protect level, each two edges after the pin changes. Writes to the clear address do not alter either bit.
- R9: A write to the status address (0) changes no flag. A read of address 3 or of the clear address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtPulse | input | 10 | One-cycle event pulses from the command, data and FIFO logic |
| cardDetRaw | input | 1 | Asynchronous card-detect pin, 1 = slot empty |
| wrProtRaw | input | 1 | Asynchronous write-protect pin |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 status, 1 clear, 2 mask |
| wrData | input | 13 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 13 | Combinational read data |
| irq | output | 1 | Level interrupt output |

## Verification
The bench sweeps every event bit one at a time. For each bit it checks that only that flag rises, that a clear write aimed at every other bit leaves it standing, and that `irq` follows only its own mask bit. A design that shifted a bit position or cleared on zeros would fail this sweep. For every bit the bench also drives a clear write in the same cycle as the event pulse, and a design where the clear wins would lose the event. It toggles the card-detect pin in both directions and counts the edges to the live bit and to the card-change flag. A design with a missing synchroniser stage, or one that detects only one direction of change, would show the wrong value at the sampled edge. It also writes ones to the live bits through the clear address, and a design that let the clear touch them would lose the card-detect level.

// File: rtl/sd_evt_pkg.sv
package sd_evt_pkg;
  localparam int EVT_W   = 11;
  localparam int SRC_W   = EVT_W - 1;
  localparam int REG_W   = EVT_W + 2;
  localparam int ADDR_W  = 2;
  localparam int CHG_BIT = EVT_W - 1;
  localparam int CD_BIT  = EVT_W;
  localparam int WP_BIT  = EVT_W + 1;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd2;

  typedef struct packed {
    logic [EVT_W-1:0] setV;
    logic [EVT_W-1:0] clrV;
    logic             maskWe;
    logic [EVT_W-1:0] maskV;
    logic             cdLive;
    logic             wpLive;
  } strobe_t;
endpackage

// File: rtl/sd_evt_ctrl.sv
module sd_evt_ctrl
  import sd_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_W-1:0]  evtPulse,
  input  logic              cardDetRaw,
  input  logic              wrProtRaw,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output strobe_t           strb
);
  localparam int NUM_LIVE = 2;
  localparam logic [NUM_LIVE-1:0] LIVE_RST = 2'b01;

  logic [NUM_LIVE-1:0] rawVec;
  logic [NUM_LIVE-1:0] syncOut;
  logic cdPrev;
  logic cdEdge;

  assign rawVec = {wrProtRaw, cardDetRaw};

  for (genvar s = 0; s < NUM_LIVE; s++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{LIVE_RST[s]}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawVec[s]};
    end
    assign syncOut[s] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cdPrev <= LIVE_RST[0];
    else       cdPrev <= syncOut[0];
  end

  assign cdEdge = syncOut[0] ^ cdPrev;

  always_comb begin
    strb.setV   = {cdEdge, evtPulse};
    strb.clrV   = (wrEn && wrAddr == ADDR_CLR) ? wrData[EVT_W-1:0] : '0;
    strb.maskWe = wrEn && wrAddr == ADDR_MASK;
    strb.maskV  = wrData[EVT_W-1:0];
    strb.cdLive = syncOut[0];
    strb.wpLive = syncOut[1];
  end
endmodule

// File: rtl/sd_evt_datapath.sv
module sd_evt_datapath
  import sd_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [EVT_W-1:0]  flagQ,
  output logic [EVT_W-1:0]  maskQ,
  output logic              irq
);
  for (genvar b = 0; b < EVT_W; b++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[b] <= 1'b0;
      else       flagQ[b] <= strb.setV[b] | (flagQ[b] & ~strb.clrV[b]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWe) maskQ <= strb.maskV;
  end

  assign irq = |(flagQ & maskQ);

  always_comb begin
    case (rdAddr)
      ADDR_STAT: rdData = {strb.wpLive, strb.cdLive, flagQ};
      ADDR_MASK: rdData = {2'b00, maskQ};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/sd_event_status.sv
module sd_event_status
  import sd_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_W-1:0]  evtPulse,
  input  logic              cardDetRaw,
  input  logic              wrProtRaw,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic              irq
);
  strobe_t          strb;
  logic [EVT_W-1:0] flagQ;
  logic [EVT_W-1:0] maskQ;

  sd_evt_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .cardDetRaw(cardDetRaw),
    .wrProtRaw(wrProtRaw), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb)
  );

  sd_evt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .rdData(rdData),
    .flagQ(flagQ), .maskQ(maskQ), .irq(irq)
  );
endmodule

// File: rtl/sd_event_status_chk.sv
module sd_event_status_chk
  import sd_evt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [SRC_W-1:0]  evtPulse,
  input strobe_t           strb,
  input logic [EVT_W-1:0]  flagQ,
  input logic [EVT_W-1:0]  maskQ,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [REG_W-1:0]  rdData,
  input logic              irq
);
  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((flagQ[SRC_W-1:0] & $past(evtPulse)) == $past(evtPulse)));

  // R3
  clear_removes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrV != '0 && strb.setV == '0) |=> ((flagQ & $past(strb.clrV)) == '0));

  // R4
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.setV & strb.clrV) != '0) |=>
      ((flagQ & $past(strb.setV & strb.clrV)) == $past(strb.setV & strb.clrV)));

  // R5
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_MASK) |-> (rdData[REG_W-1:EVT_W] == 2'b00));

  // R6
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);

  // R7
  card_change_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setV[CHG_BIT] |=> flagQ[CHG_BIT]);
endmodule

bind sd_event_status sd_event_status_chk u_chk (
  .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .strb(strb), .flagQ(flagQ),
  .maskQ(maskQ), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
);

// File: tb/test_sd_event_status.sv
module test_sd_event_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  evtPulse = '0;
  logic        cardDetRaw = 1'b1;
  logic        wrProtRaw = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [12:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [12:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sd_event_status i_sd_event_status (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .cardDetRaw(cardDetRaw),
    .wrProtRaw(wrProtRaw), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [12:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [12:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] p);
    evtPulse = p;
    step();
    evtPulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] v;
    logic [12:0] live;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    live = 13'h0800;

    // R1 reset state
    rd(2'd0, v); chk("R1 status", v, live);
    rd(2'd2, v); chk("R1 mask", v, 13'h0);
    chk("R1 irq", {12'h0, irq}, 13'h0);

    for (int i = 0; i < 10; i++) begin
      logic [12:0] one;
      one = 13'h1 << i;
      pulse(10'(one));
      rd(2'd0, v); chk("R2 set bit", v, live | one);
      step();
      rd(2'd0, v); chk("R2 sticky", v, live | one);
      chk("R6 zero mask irq", {12'h0, irq}, 13'h0);
      wr(2'd2, one);
      chk("R6 irq enabled", {12'h0, irq}, 13'h1);
      wr(2'd2, ~one & 13'h07FF);
      chk("R6 other masks", {12'h0, irq}, 13'h0);
      wr(2'd0, 13'h07FF);
      rd(2'd0, v); chk("R9 status write ignored", v, live | one);
      wr(2'd1, ~one & 13'h07FF);
      rd(2'd0, v); chk("R3 zeros keep", v, live | one);
      wr(2'd1, one);
      rd(2'd0, v); chk("R3 ones clear", v, live);
      // R4 collision: event and clear in same cycle
      evtPulse = 10'(one); wrEn = 1'b1; wrAddr = 2'd1; wrData = one;
      step();
      evtPulse = '0; wrEn = 1'b0;
      rd(2'd0, v); chk("R4 set wins", v, live | one);
      wr(2'd1, 13'h07FF);
      wr(2'd2, 13'h0);
    end

    // R5 mask readback
    wr(2'd2, 13'h1FFF);
    rd(2'd2, v); chk("R5 mask readback", v, 13'h07FF);
    wr(2'd2, 13'h0555);
    rd(2'd2, v); chk("R5 mask pattern", v, 13'h0555);
    wr(2'd2, 13'h0);
    // R9 unmapped reads
    rd(2'd3, v); chk("R9 addr3 zero", v, 13'h0);
    rd(2'd1, v); chk("R9 clear addr zero", v, 13'h0);

    // R7/R8 card insert (falling edge)
    cardDetRaw = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk("R8 one edge", v, 13'h0800);
    @(negedge clk);
    rd(2'd0, v); chk("R8 live after two", v, 13'h0000);
    @(negedge clk);
    rd(2'd0, v); chk("R7 change after three", v, 13'h0400);
    wr(2'd2, 13'h0400);
    chk("R6 card irq", {12'h0, irq}, 13'h1);
    wr(2'd1, 13'h1C00);
    rd(2'd0, v); chk("R3 clear change", v, 13'h0000);
    chk("R6 irq drops", {12'h0, irq}, 13'h0);

    // R8 write protect
    wrProtRaw = 1'b1;
    step(); step();
    rd(2'd0, v); chk("R8 wp live", v, 13'h1000);
    wr(2'd1, 13'h1800);
    rd(2'd0, v); chk("R8 clear no effect", v, 13'h1000);

    // R7 card removal (rising edge)
    cardDetRaw = 1'b1;
    step(); step();
    rd(2'd0, v); chk("R8 removed live", v, 13'h1800);
    step();
    rd(2'd0, v); chk("R7 rising change", v, 13'h1C00);
    wr(2'd1, 13'h1FFF);
    rd(2'd0, v); chk("R8 live kept", v, 13'h1800);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule